// File: doc/BRIEF.md
# Dual-State Program Counter Unit

This unit holds the instruction address of a core that runs in one of two instruction-set states. The first is a wide state whose instructions are 32 bits long. The second is a compact state whose instructions are 16 bits long. The `compact` input selects the state. On each cycle with `advance` set, the address moves forward by the size of one instruction in that state.

The address can also be redirected. A taken branch loads its destination. An ordinary data write to the program counter also loads a new address, so copying the saved link value into it performs a subroutine return. Whenever the unit loads an address, it clears the low bits so that the address is aligned for the current state.

The unit drives three values:
- the address of the current instruction;
- the value an instruction sees when it reads the program counter, which lies ahead of the instruction by the pipeline offset;
- the return address that a call stores in the link register.

Top module: `dual_state_pc`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) loads address 0x0. Reset takes priority over every other input.
- R2: In wide state (`compact`=0), a cycle with `advance` set and no redirect adds 4 to `fetch_addr`.
- R3: In compact state (`compact`=1), a cycle with `advance` set and no redirect adds 2 to `fetch_addr`.
- R4: `pc_view` equals `fetch_addr` + 8 in wide state and `fetch_addr` + 4 in compact state. It follows `compact` combinationally.
- R5: `link_addr` equals `fetch_addr` + 4 in wide state and `fetch_addr` + 2 in compact state. This is the address of the next sequential instruction.
- R6: `br_take` loads `br_target` in place of the sequential increment, even when `advance` is also set.
- R7: `pc_wr` loads `pc_wdata`, and this load also overrides `advance`. If `br_take` and `pc_wr` are both set, `br_take` wins.
- R8: Every loaded address is aligned for the current state. Bit 0 is cleared in compact state. Bits 1:0 are cleared in wide state.
- R9: With `advance`, `br_take` and `pc_wr` all low, `fetch_addr` holds its value.
- R10: Sequential advance wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| compact | input | 1 | 1 = 16-bit compact state, 0 = 32-bit wide state |
| advance | input | 1 | Step to the next sequential instruction |
| br_take | input | 1 | Taken branch, load `br_target` |
| br_target | input | ADDR_W | Branch destination |
| pc_wr | input | 1 | Data write to the program counter |
| pc_wdata | input | ADDR_W | Value written to the program counter, such as the link value |
| fetch_addr | output | ADDR_W | Address of the current instruction |
| pc_view | output | ADDR_W | Program counter value as read by an instruction |
| link_addr | output | ADDR_W | Return address to capture on a call |

## Verification
A vector table runs the unit through four kinds of input pattern:
- Sequential runs in each state, including a switch from wide to compact mid-run. These separate the two step sizes, and they show that the step follows the current state and not the state at load time.
- Branches and writes carrying misaligned values in both states. These expose alignment masks that are wrong or applied to the wrong state.
- Cycles where a redirect and `advance` are set together, and where a branch and a write are set together. These pin down the priority order.
- Runs that cross the top of the address space, plus a reset during a branch. These show the wrap and that reset comes first.

// File: rtl/dual_state_pc.sv
module dual_state_pc #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              compact,
  input  logic              advance,
  input  logic              br_take,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              pc_wr,
  input  logic [ADDR_W-1:0] pc_wdata,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] pc_view,
  output logic [ADDR_W-1:0] link_addr
);
  localparam logic [ADDR_W-1:0] WIDE_STEP    = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] COMPACT_STEP = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] WIDE_MASK    = ~ADDR_W'(3);
  localparam logic [ADDR_W-1:0] COMPACT_MASK = ~ADDR_W'(1);
  localparam logic [ADDR_W-1:0] RESET_ADDR   = '0;

  logic [ADDR_W-1:0] pc_q;
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] mask;
  logic [ADDR_W-1:0] redirect_addr;

  assign step          = compact ? COMPACT_STEP : WIDE_STEP;
  assign mask          = compact ? COMPACT_MASK : WIDE_MASK;
  assign redirect_addr = (br_take ? br_target : pc_wdata) & mask;

  always_ff @(posedge clk) begin
    if (rst)                  pc_q <= RESET_ADDR;
    else if (br_take || pc_wr) pc_q <= redirect_addr;
    else if (advance)         pc_q <= pc_q + step;
  end

  assign fetch_addr = pc_q;
  assign link_addr  = pc_q + step;
  assign pc_view    = pc_q + (step << 1);
endmodule

module dual_state_pc_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              compact,
  input logic              advance,
  input logic              br_take,
  input logic [ADDR_W-1:0] br_target,
  input logic              pc_wr,
  input logic [ADDR_W-1:0] pc_wdata,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [ADDR_W-1:0] pc_view,
  input logic [ADDR_W-1:0] link_addr
);
  a_r2_wide_step: assert property (@(posedge clk) disable iff (rst)
    (advance && !br_take && !pc_wr && !compact) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(4));

  a_r3_compact_step: assert property (@(posedge clk) disable iff (rst)
    (advance && !br_take && !pc_wr && compact) |=> fetch_addr == $past(fetch_addr) + ADDR_W'(2));

  a_r4_view_gap: assert property (@(posedge clk) disable iff (rst)
    (pc_view - link_addr) == (compact ? ADDR_W'(2) : ADDR_W'(4)));

  a_r6_branch_load: assert property (@(posedge clk) disable iff (rst)
    br_take |=> fetch_addr[ADDR_W-1:2] == $past(br_target[ADDR_W-1:2]));

  a_r7_write_load: assert property (@(posedge clk) disable iff (rst)
    (pc_wr && !br_take) |=> fetch_addr[ADDR_W-1:2] == $past(pc_wdata[ADDR_W-1:2]));

  a_r8_aligned: assert property (@(posedge clk) disable iff (rst)
    (br_take || pc_wr) |=> (fetch_addr[0] == 1'b0) && ($past(compact) || fetch_addr[1] == 1'b0));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!advance && !br_take && !pc_wr) |=> $stable(fetch_addr));
endmodule

bind dual_state_pc dual_state_pc_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dual_state_pc_test.sv
module dual_state_pc_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  logic clk = 0, rst = 1, compact = 0, advance = 0, br_take = 0, pc_wr = 0;
  logic [31:0] br_target = 0, pc_wdata = 0;
  logic [31:0] fetch_addr, pc_view, link_addr;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_state_pc #(.ADDR_W(32)) uut (.*);

  // {rst, advance, compact, br_take, pc_wr, data, expected fetch}
  localparam logic [68:0] VEC [0:NV-1] = '{
    {5'b10000, 32'h0,        32'h0},         // R1
    {5'b01000, 32'h0,        32'h4},         // R2
    {5'b01000, 32'h0,        32'h8},         // R2
    {5'b01100, 32'h0,        32'hA},         // R3
    {5'b01100, 32'h0,        32'hC},         // R3
    {5'b00000, 32'h0,        32'hC},         // R9
    {5'b00010, 32'h103,      32'h100},       // R6 R8
    {5'b00101, 32'h2001,     32'h2000},      // R7 R8
    {5'b00110, 32'h3337,     32'h3336},      // R6 R8
    {5'b01100, 32'h0,        32'h3338},      // R3
    {5'b01000, 32'h0,        32'h333C},      // R2
    {5'b00001, 32'hFFFFFFFF, 32'hFFFFFFFC},  // R7 R8
    {5'b01000, 32'h0,        32'h0},         // R10
    {5'b01010, 32'h500,      32'h500},       // R6 over advance
    {5'b11000, 32'h0,        32'h0}          // R1
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic [31:0] exp);
    check(req, fetch_addr, exp);
    check("R4", pc_view, exp + (compact ? 32'd4 : 32'd8));
    check("R5", link_addr, exp + (compact ? 32'd2 : 32'd4));
  endtask

  task automatic step(input logic r, a, c, b, w, input logic [31:0] bt, wd);
    {rst, advance, compact, br_take, pc_wr} = {r, a, c, b, w};
    br_target = bt;
    pc_wdata = wd;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][68], VEC[i][67], VEC[i][66], VEC[i][65], VEC[i][64],
           VEC[i][63:32], VEC[i][63:32]);
      check_all($sformatf("vector %0d R1/R2/R3/R6/R7/R8/R9/R10", i), VEC[i][31:0]);
    end

    // R7: branch wins over a simultaneous write
    step(0, 1, 0, 1, 1, 32'h601, 32'h700);
    check_all("R7 branch beats write", 32'h600);

    // R10: wrap in compact state
    step(0, 0, 1, 1, 0, 32'hFFFFFFFF, 32'h0);
    check_all("R8 compact align", 32'hFFFFFFFE);
    step(0, 1, 1, 0, 0, 32'h0, 32'h0);
    check_all("R10 compact wrap", 32'h0);

    // R9: idle hold across cycles with the data inputs moving
    step(0, 0, 0, 0, 1, 32'h0, 32'h1234);
    check_all("R7 write", 32'h1234);
    for (int k = 0; k < 3; k++) begin
      step(0, 0, 0, 0, 0, 32'hDEAD0000 + k, 32'hBEEF0000 + k);
      check_all("R9 hold", 32'h1234);
    end

    // R1: reset beats a branch
    step(1, 1, 0, 1, 1, 32'h800, 32'h900);
    check_all("R1 reset priority", 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule